// File: doc/BRIEF.md
# Accumulator-Conditioned Branch Sequencer

This block works out the next program counter for the control-flow group of a 16-bit accumulator machine. Each cycle that `exec_valid` is high it takes the current instruction word, the current program counter, the accumulator and the word stored just after the instruction. It then produces the address the machine continues from. It only acts on instructions whose top four bits are zero; every other group is left to other logic and produces no result here.

Bit 11 splits the group in two. With bit 11 clear, bits 10:8 pick a branch condition that is tested against the accumulator, read as a two's-complement number. Condition 0 is an unconditional long jump that takes its target from the following word. The other conditions take a short target, the low byte of the instruction zero-extended. With bit 11 set, bits 10:8 pick a call, a return or one of six reserved codes. Calls and returns use a small return-address stack inside the block. Misuse of that stack raises a sticky error flag, and the program counter then simply moves on.

The result is registered: it appears on `next_pc` one clock after the instruction is presented, qualified by a single-cycle `res_valid`.

Top module: `bsq_branch_seq`

## Requirements
- R1: An instruction presented with `exec_valid` high whose bits 15:12 are not zero produces no `res_valid` pulse and leaves the return stack untouched; a later return still pops the address pushed before it.
- R2: Bits 15:8 equal to 0x00 (branch, condition 0) always set `taken` and load `next_pc` with `follow_word`.
- R3: With bit 11 clear, condition codes 1 to 6 in bits 10:8 branch when the signed accumulator is, in turn, above zero, below zero (bit 15 set), non-zero, zero, zero or above, zero or below; a taken branch loads `next_pc` with bits 7:0 zero-extended.
- R4: Condition code 7 with bit 11 clear branches whatever the accumulator holds, to bits 7:0 zero-extended.
- R5: A branch that is not taken gives `taken` low and `next_pc` equal to `pc + 1`, wrapping at 16 bits.
- R6: Bit 11 set with bits 10:8 equal to 0 is a call: it pushes `pc + 2` on the return stack, sets `taken` and loads `next_pc` from `follow_word`.
- R7: Bit 11 set with bits 10:8 equal to 1 is a return: it pops the most recent pushed address into `next_pc` with `taken` high, in last-in first-out order.
- R8: A call made while the stack already holds `STACK_DEPTH` entries pushes nothing, sets `stack_err`, and gives `next_pc = pc + 2` with `taken` low.
- R9: A return made with the stack empty sets `stack_err` and gives `next_pc = pc + 1` with `taken` low.
- R10: `stack_err` stays high once set, until reset.
- R11: Bit 11 set with bits 10:8 from 2 to 7 (whole-field codes 10 to 15) gives `next_pc = pc + 1`, `taken` low, and `reserved_hit` high for the one result cycle only.
- R12: The result for an instruction appears exactly one clock after it is presented, and `res_valid` is high only in that cycle. After reset `res_valid`, `reserved_hit` and `stack_err` are low and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_valid | input | 1 | Instruction on the inputs is to be executed this cycle |
| instr | input | 16 | Current instruction word |
| pc | input | PC_W | Address of the current instruction |
| acc | input | ACC_W | Accumulator value |
| follow_word | input | PC_W | Word stored at `pc + 1` |
| res_valid | output | 1 | `next_pc` carries a fresh result |
| next_pc | output | PC_W | Address to continue from |
| taken | output | 1 | Control moved away from sequential flow |
| reserved_hit | output | 1 | The result came from a reserved code |
| stack_err | output | 1 | Sticky return-stack overflow or underflow flag |

## Verification
The bench builds the block with a 16-bit program counter and accumulator, and with a return stack only four entries deep. The shallow stack lets a short run fill the stack completely and then probe the overflow call. The same run checks that the last pushed address survives the refused call, and it also reaches the underflow return. The 16-bit widths let the bench check the sign boundary of the accumulator (0x8000, 0x0000, small positive values) and program counter wrap at 0xFFFF directly.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

   // Which flavour of control-flow instruction a decoded word is
   typedef enum logic [1:0] {
      KIND_BRANCH = 2'd0,
      KIND_CALL   = 2'd1,
      KIND_RET    = 2'd2,
      KIND_RSVD   = 2'd3
   } flow_kind_e;

   localparam int INSTR_W   = 16;
   localparam int GROUP_W   = 4;
   localparam int COND_W    = 3;
   localparam int PAYLOAD_W = 8;

   typedef struct packed {
      logic                  in_group;
      flow_kind_e            kind;
      logic [COND_W-1:0]     cond;
      logic [PAYLOAD_W-1:0]  payload;
   } flow_dec_t;

endpackage

// File: rtl/bsq_decode.sv
module bsq_decode
   import bsq_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output flow_dec_t          dec
);

   always_comb begin
      dec.in_group = (instr[INSTR_W-1 -: GROUP_W] == '0);
      dec.cond     = instr[10:8];
      dec.payload  = instr[PAYLOAD_W-1:0];
      if (!instr[11]) begin
         dec.kind = KIND_BRANCH;
      end else begin
         case (instr[10:8])
            3'd0:    dec.kind = KIND_CALL;
            3'd1:    dec.kind = KIND_RET;
            default: dec.kind = KIND_RSVD;
         endcase
      end
   end

endmodule

// File: rtl/bsq_cond_eval.sv
module bsq_cond_eval
   import bsq_pkg::*;
#(
   parameter int ACC_W = 16
)(
   input  logic [ACC_W-1:0]  acc,
   input  logic [COND_W-1:0] cond,
   output logic              take
);

   localparam int NUM_COND = 1 << COND_W;

   logic is_neg;
   logic is_zero;
   logic is_pos;
   logic [NUM_COND-1:0] take_vec;

   generate
      if (ACC_W < 2) begin : g_bad_acc
         $error("bsq_cond_eval: ACC_W must be at least 2");
      end
   endgenerate

   assign is_neg  = acc[ACC_W-1];
   assign is_zero = (acc == '0);
   assign is_pos  = !is_neg && !is_zero;

   // One condition per code; the index is the condition field value
   always_comb begin
      take_vec    = '0;
      take_vec[0] = 1'b1;               // long jump
      take_vec[1] = is_pos;
      take_vec[2] = is_neg;
      take_vec[3] = !is_zero;
      take_vec[4] = is_zero;
      take_vec[5] = !is_neg;
      take_vec[6] = is_neg || is_zero;
      take_vec[7] = 1'b1;               // short, unconditional
   end

   assign take = take_vec[cond];

endmodule

// File: rtl/bsq_ret_stack.sv
module bsq_ret_stack #(
   parameter int DEPTH = 8,
   parameter int W     = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] top,
   output logic         full,
   output logic         empty
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] cnt;
   logic [W-1:0]     mem [DEPTH];

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("bsq_ret_stack: DEPTH must be at least 1");
      end
   endgenerate

   assign full  = (cnt == CNT_W'(DEPTH));
   assign empty = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (push && !full) begin
         cnt <= cnt + 1'b1;
      end else if (pop && !empty) begin
         cnt <= cnt - 1'b1;
      end
   end

   // Each entry owns its write enable: it is written when it is the next free slot
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_entry
         localparam logic [CNT_W-1:0] SLOT = CNT_W'(g);
         always_ff @(posedge clk) begin
            if (push && !full && (cnt == SLOT)) begin
               mem[g] <= din;
            end
         end
      end
   endgenerate

   always_comb begin
      top = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cnt == CNT_W'(i + 1)) begin
            top = mem[i];
         end
      end
   end

endmodule

// File: rtl/bsq_branch_seq.sv
module bsq_branch_seq
   import bsq_pkg::*;
#(
   parameter int PC_W        = 16,
   parameter int ACC_W       = 16,
   parameter int STACK_DEPTH = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exec_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [PC_W-1:0]    pc,
   input  logic [ACC_W-1:0]   acc,
   input  logic [PC_W-1:0]    follow_word,
   output logic               res_valid,
   output logic [PC_W-1:0]    next_pc,
   output logic               taken,
   output logic               reserved_hit,
   output logic               stack_err
);

   generate
      if (PC_W < PAYLOAD_W) begin : g_bad_pc
         $error("bsq_branch_seq: PC_W must hold the short target");
      end
      if (STACK_DEPTH < 1) begin : g_bad_stack
         $error("bsq_branch_seq: STACK_DEPTH must be at least 1");
      end
   endgenerate

   flow_dec_t        dec;
   logic             cond_take;
   logic             stk_full;
   logic             stk_empty;
   logic [PC_W-1:0]  stk_top;
   logic             fire;
   logic [PC_W-1:0]  seq_one;
   logic [PC_W-1:0]  seq_two;
   logic [PC_W-1:0]  short_tgt;
   logic [PC_W-1:0]  nxt;
   logic             nxt_taken;
   logic             want_push;
   logic             want_pop;
   logic             err_now;
   logic             rsv_now;

   bsq_decode u_decode (
      .instr (instr),
      .dec   (dec)
   );

   bsq_cond_eval #(.ACC_W(ACC_W)) u_cond (
      .acc  (acc),
      .cond (dec.cond),
      .take (cond_take)
   );

   assign fire      = exec_valid && dec.in_group;
   assign seq_one   = pc + PC_W'(1);
   assign seq_two   = pc + PC_W'(2);
   assign short_tgt = PC_W'(dec.payload);

   always_comb begin
      nxt       = seq_one;
      nxt_taken = 1'b0;
      want_push = 1'b0;
      want_pop  = 1'b0;
      err_now   = 1'b0;
      rsv_now   = 1'b0;
      case (dec.kind)
         KIND_BRANCH: begin
            if (cond_take) begin
               nxt_taken = 1'b1;
               nxt       = (dec.cond == '0) ? follow_word : short_tgt;
            end
         end
         KIND_CALL: begin
            if (stk_full) begin
               err_now = 1'b1;
               nxt     = seq_two;
            end else begin
               want_push = 1'b1;
               nxt_taken = 1'b1;
               nxt       = follow_word;
            end
         end
         KIND_RET: begin
            if (stk_empty) begin
               err_now = 1'b1;
            end else begin
               want_pop  = 1'b1;
               nxt_taken = 1'b1;
               nxt       = stk_top;
            end
         end
         default: begin
            rsv_now = 1'b1;
         end
      endcase
   end

   bsq_ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fire && want_push),
      .pop   (fire && want_pop),
      .din   (seq_two),
      .top   (stk_top),
      .full  (stk_full),
      .empty (stk_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         next_pc      <= '0;
         taken        <= 1'b0;
         reserved_hit <= 1'b0;
         stack_err    <= 1'b0;
      end else begin
         res_valid    <= fire;
         reserved_hit <= fire && rsv_now;
         if (fire) begin
            next_pc <= nxt;
            taken   <= nxt_taken;
         end
         if (fire && err_now) begin
            stack_err <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/bsq_branch_seq_chk.sv
module bsq_branch_seq_chk #(
   parameter int PC_W  = 16,
   parameter int ACC_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             exec_valid,
   input logic [15:0]      instr,
   input logic [PC_W-1:0]  pc,
   input logic [ACC_W-1:0] acc,
   input logic [PC_W-1:0]  follow_word,
   input logic             res_valid,
   input logic [PC_W-1:0]  next_pc,
   input logic             taken,
   input logic             reserved_hit,
   input logic             stack_err
);

   // R12
   result_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($past(exec_valid) && ($past(instr[15:12]) == 4'h0)));

   // R1
   other_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && (instr[15:12] != 4'h0)) |=> !res_valid);

   // R2
   long_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && (instr[15:8] == 8'h00)) |=> (taken && (next_pc == $past(follow_word))));

   // R4
   always_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && (instr[15:8] == 8'h07)) |=> (taken && (next_pc == PC_W'($past(instr[7:0])))));

   // R10
   sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stack_err |=> stack_err);

   // R11
   reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && (instr[15:12] == 4'h0) && instr[11] && (instr[10:8] >= 3'd2))
      |=> (reserved_hit && !taken && (next_pc == PC_W'($past(pc) + 1'b1))));

   // R11
   reserved_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reserved_hit |-> res_valid);

endmodule

bind bsq_branch_seq bsq_branch_seq_chk #(.PC_W(PC_W), .ACC_W(ACC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .exec_valid   (exec_valid),
   .instr        (instr),
   .pc           (pc),
   .acc          (acc),
   .follow_word  (follow_word),
   .res_valid    (res_valid),
   .next_pc      (next_pc),
   .taken        (taken),
   .reserved_hit (reserved_hit),
   .stack_err    (stack_err)
);

// File: tb/bsq_branch_seq_test.sv
module bsq_branch_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_valid = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] pc = '0;
   logic [15:0] acc = '0;
   logic [15:0] follow_word = '0;
   logic        res_valid;
   logic [15:0] next_pc;
   logic        taken;
   logic        reserved_hit;
   logic        stack_err;

   int n_chk = 0;
   int n_err = 0;

   typedef struct {
      logic [15:0] pc;
      logic        tk;
      logic        rsv;
      string       tag;
   } exp_t;

   exp_t sbq[$];

   always #2 clk = ~clk;

   bsq_branch_seq #(.PC_W(16), .ACC_W(16), .STACK_DEPTH(4)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .exec_valid   (exec_valid),
      .instr        (instr),
      .pc           (pc),
      .acc          (acc),
      .follow_word  (follow_word),
      .res_valid    (res_valid),
      .next_pc      (next_pc),
      .taken        (taken),
      .reserved_hit (reserved_hit),
      .stack_err    (stack_err)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [15:0] ins, input logic [15:0] pc_i, input logic [15:0] acc_i,
                        input logic [15:0] fw_i, input logic [15:0] epc, input logic etk,
                        input logic ersv, input string tag);
      exp_t e;
      @(negedge clk);
      instr       = ins;
      pc          = pc_i;
      acc         = acc_i;
      follow_word = fw_i;
      exec_valid  = 1'b1;
      if (ins[15:12] == 4'h0) begin
         e.pc = epc; e.tk = etk; e.rsv = ersv; e.tag = tag;
         sbq.push_back(e);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         exec_valid = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      exec_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R12 reset res_valid", {15'd0, res_valid}, 16'h0);
      check(stack_err == 1'b0, "R12 reset stack_err", {15'd0, stack_err}, 16'h0);
      check(reserved_hit == 1'b0, "R12 reset reserved_hit", {15'd0, reserved_hit}, 16'h0);
      rst_n = 1'b1;
   endtask

   // Monitor: pops one expected item per result
   always @(negedge clk) begin
      if (rst_n) begin
         if (res_valid) begin
            if (sbq.size() == 0) begin
               check(1'b0, "R1/R12 unexpected result", next_pc, 16'h0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               check(next_pc == e.pc, {e.tag, " next_pc"}, next_pc, e.pc);
               check(taken == e.tk, {e.tag, " taken"}, {15'd0, taken}, {15'd0, e.tk});
               check(reserved_hit == e.rsv, {e.tag, " reserved_hit"}, {15'd0, reserved_hit}, {15'd0, e.rsv});
            end
         end else if (reserved_hit) begin
            check(1'b0, "R11 strobe without result", 16'h1, 16'h0);
         end
      end
   end

   initial begin
      #(4 * 20000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] accv [3];
      logic [6:0]  mask [3];
      accv[0] = 16'h0005; mask[0] = 7'h2A;  // positive
      accv[1] = 16'h0000; mask[1] = 7'h70;  // zero
      accv[2] = 16'h8000; mask[2] = 7'h4C;  // most negative

      do_reset();

      // R2 long jump
      issue(16'h0000, 16'h0100, 16'h0000, 16'h1234, 16'h1234, 1'b1, 1'b0, "R2");

      // R3 / R5 conditions against three accumulator values, back to back
      for (int a = 0; a < 3; a++) begin
         for (int c = 1; c < 7; c++) begin
            logic [15:0] ins;
            logic        tk;
            ins = {4'h0, 1'b0, 3'(c), 8'h40 + 8'(c)};
            tk  = mask[a][c];
            issue(ins, 16'h0200, accv[a], 16'hBEEF,
                  tk ? {8'h00, 8'h40 + 8'(c)} : 16'h0201, tk, 1'b0, tk ? "R3" : "R5");
         end
      end

      // R4 always branch with negative accumulator
      issue(16'h07FF, 16'h0300, 16'h8000, 16'h0000, 16'h00FF, 1'b1, 1'b0, "R4");
      // R5 wrap of pc
      issue(16'h0110, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, "R5 wrap");
      idle(2);

      // R6 / R7 nested call and return
      issue(16'h0800, 16'h0300, 16'h0000, 16'h4000, 16'h4000, 1'b1, 1'b0, "R6");
      issue(16'h0800, 16'h4000, 16'h0000, 16'h5000, 16'h5000, 1'b1, 1'b0, "R6");
      issue(16'h0900, 16'h5010, 16'h0000, 16'h0000, 16'h4002, 1'b1, 1'b0, "R7");
      issue(16'h0900, 16'h4010, 16'h0000, 16'h0000, 16'h0302, 1'b1, 1'b0, "R7");

      // R1 other groups leave the stack alone
      issue(16'h0800, 16'h0600, 16'h0000, 16'h6000, 16'h6000, 1'b1, 1'b0, "R6");
      issue(16'h1800, 16'h6000, 16'h0000, 16'h7000, 16'h0000, 1'b0, 1'b0, "R1");
      issue(16'h3900, 16'h6001, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, "R1");
      issue(16'h0900, 16'h6002, 16'h0000, 16'h0000, 16'h0602, 1'b1, 1'b0, "R1 R7");
      idle(1);
      check(stack_err == 1'b0, "R1 no error", {15'd0, stack_err}, 16'h0);

      // R9 underflow
      issue(16'h0900, 16'h0700, 16'h0000, 16'h0000, 16'h0701, 1'b0, 1'b0, "R9");
      idle(1);
      check(stack_err == 1'b1, "R9 stack_err", {15'd0, stack_err}, 16'h1);
      // R10 sticky across later good instructions
      issue(16'h0700, 16'h0710, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, "R4");
      idle(3);
      check(stack_err == 1'b1, "R10 sticky", {15'd0, stack_err}, 16'h1);

      do_reset();

      // R8 overflow with a four-entry stack
      for (int i = 0; i < 4; i++) begin
         issue(16'h0800, 16'h1000 + 16'(i * 16), 16'h0000, 16'h2000 + 16'(i),
               16'h2000 + 16'(i), 1'b1, 1'b0, "R6");
      end
      issue(16'h0800, 16'h1100, 16'h0000, 16'h3000, 16'h1102, 1'b0, 1'b0, "R8");
      idle(1);
      check(stack_err == 1'b1, "R8 stack_err", {15'd0, stack_err}, 16'h1);
      issue(16'h0900, 16'h1200, 16'h0000, 16'h0000, 16'h1032, 1'b1, 1'b0, "R8 R7");
      issue(16'h0900, 16'h1201, 16'h0000, 16'h0000, 16'h1022, 1'b1, 1'b0, "R7");

      // R11 reserved codes, each followed directly by a branch
      for (int c = 10; c < 16; c++) begin
         issue({4'h0, 4'(c), 8'h33}, 16'h0800 + 16'(c), 16'h0000, 16'h0000,
               16'h0801 + 16'(c), 1'b0, 1'b1, "R11");
         issue(16'h0744, 16'h0900, 16'h0000, 16'h0000, 16'h0044, 1'b1, 1'b0, "R11 R12 one cycle");
      end

      idle(3);
      check(sbq.size() == 0, "R12 all results seen", 16'(sbq.size()), 16'h0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule